// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address that missed in the translation lookaside buffer. It takes one walk request, made of a 32-bit virtual address and a translation table base, and reads descriptors from physical memory through a simple request/valid read port. The first fetch always targets the level-one table. A section descriptor finishes the walk at once. A coarse or fine table descriptor points at a level-two table, and a second fetch brings back a large, small or tiny page descriptor.

When the walk ends, the block gives a one-cycle result. It is either a completed translation, which carries the physical address and the access permission bits and writes one entry into the TLB in the same cycle, or a translation fault that records which level failed. Only one walk is in flight at a time. While `busy` is high the requester must hold off, and any request shown during that time is ignored.

Top module: `xlat_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `mem_req`, `done_valid`, `fault_valid` and `tlb_wr_en` are all low.
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle up to the cycle before the result. A `req_valid` raised while `busy` is high is ignored, so no further walk or memory fetch follows.
- R3: The level-one fetch address is `{ttb[31:14], va[31:20], 2'b00}`. `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen.
- R4: A level-one descriptor with bits [1:0] = 10 is a 1 MB section. The walk ends after that single fetch with PA = `{d[31:20], va[19:0]}`, AP = `d[11:10]`, domain = `d[8:5]` and size code 0.
- R5: A level-one descriptor with bits [1:0] = 01 is a coarse table. The second fetch reads `{d[31:10], va[19:12], 2'b00}`.
- R6: A level-one descriptor with bits [1:0] = 11 is a fine table. The second fetch reads `{d[31:12], va[19:10], 2'b00}`.
- R7: A level-two descriptor with bits [1:0] = 01 is a 64 KB large page: PA = `{d[31:16], va[15:0]}`, size code 1.
- R8: A level-two descriptor with bits [1:0] = 10 is a 4 KB small page: PA = `{d[31:12], va[11:0]}`, size code 2.
- R9: A level-two descriptor with bits [1:0] = 11 is a 1 KB tiny page: PA = `{d[31:10], va[9:0]}`, size code 3. For every page size, AP = `d[5:4]` of the level-two descriptor, and the domain comes from the level-one descriptor.
- R10: Bits [1:0] = 00 at either level end the walk with `fault_valid` and no TLB write. `fault_level` is 0 for a level-one fault, which makes no second fetch, and 1 for a level-two fault.
- R11: The result is a one-cycle pulse in the cycle after the final `mem_valid`. `done_valid` and `fault_valid` never coincide. `tlb_wr_en` is high exactly with `done_valid`, and it writes the request's VA, the PA, AP, size code and domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_va | input | ADDR_W | Virtual address to translate |
| req_ttb | input | ADDR_W | Translation table base |
| busy | output | 1 | A walk is in progress, so new requests stall |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Descriptor read address |
| mem_valid | input | 1 | Read data valid, which completes the current fetch |
| mem_rdata | input | ADDR_W | Descriptor word |
| done_valid | output | 1 | Translation completed (pulse) |
| done_pa | output | ADDR_W | Translated physical address |
| done_ap | output | 2 | Access permission bits |
| fault_valid | output | 1 | Translation fault (pulse) |
| fault_level | output | 1 | 0 = level-one fault, 1 = level-two fault |
| tlb_wr_en | output | 1 | TLB entry write strobe |
| tlb_wr_va | output | ADDR_W | VA of the new entry |
| tlb_wr_pa | output | ADDR_W | PA of the new entry |
| tlb_wr_ap | output | 2 | AP of the new entry |
| tlb_wr_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| tlb_wr_dom | output | 4 | Domain of the new entry |

## Verification
The bound checker watches several properties on every cycle. The fetch address must hold while a read waits, and results must follow a memory reply by one cycle. A done and a fault must never coincide, and a fault must never write the TLB. Section and small-page entries must keep the untranslated low VA bits, and `busy` may only rise after a request. The bench scenarios cover what needs a whole walk to show. These are the decoding of each descriptor kind into the right second address and page size, the fetch count per walk type, the fault level, and the fact that a request raised mid-walk is dropped.

// File: rtl/xlat_walk_pkg.sv
package xlat_walk_pkg;

   typedef enum logic [1:0] {
      L1_FAULT   = 2'b00,
      L1_COARSE  = 2'b01,
      L1_SECTION = 2'b10,
      L1_FINE    = 2'b11
   } l1_kind_e;

   typedef enum logic [1:0] {
      PG_SECTION = 2'd0,
      PG_LARGE   = 2'd1,
      PG_SMALL   = 2'd2,
      PG_TINY    = 2'd3
   } pg_size_e;

   typedef enum logic [1:0] {
      W_IDLE = 2'd0,
      W_L1   = 2'd1,
      W_L2   = 2'd2
   } walk_state_e;

   // offset widths of each mapping granule
   localparam int SEC_SHIFT   = 20;
   localparam int LARGE_SHIFT = 16;
   localparam int SMALL_SHIFT = 12;
   localparam int TINY_SHIFT  = 10;
   localparam int TTB_SHIFT   = 14;
   localparam int AP_W        = 2;
   localparam int DOM_W       = 4;

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
   import xlat_walk_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter bit FINE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output l1_kind_e          kind,
   output logic [ADDR_W-1:0] sec_pa,
   output logic [ADDR_W-1:0] l2_addr,
   output logic [AP_W-1:0]   ap,
   output logic [DOM_W-1:0]  dom
);

   if (FINE_EN) begin : g_fine
      assign kind = l1_kind_e'(desc[1:0]);
   end else begin : g_no_fine
      // without fine tables, that encoding is treated as a fault
      assign kind = (desc[1:0] == 2'b11) ? L1_FAULT : l1_kind_e'(desc[1:0]);
   end

   assign sec_pa = {desc[ADDR_W-1:SEC_SHIFT], va[SEC_SHIFT-1:0]};
   assign ap     = desc[11:10];
   assign dom    = desc[8:5];

   always_comb begin
      case (kind)
         L1_COARSE: l2_addr = {desc[ADDR_W-1:10], va[SEC_SHIFT-1:SMALL_SHIFT], 2'b00};
         L1_FINE:   l2_addr = {desc[ADDR_W-1:12], va[SEC_SHIFT-1:TINY_SHIFT], 2'b00};
         default:   l2_addr = '0;
      endcase
   end

   logic unused_l1_bits;
   assign unused_l1_bits = ^{desc[9], desc[4:2]};

endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
   import xlat_walk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output logic              fault,
   output pg_size_e          size,
   output logic [ADDR_W-1:0] pa,
   output logic [AP_W-1:0]   ap
);

   assign ap = desc[5:4];

   always_comb begin
      fault = 1'b0;
      size  = PG_SMALL;
      pa    = '0;
      case (desc[1:0])
         2'b01: begin
            size = PG_LARGE;
            pa   = {desc[ADDR_W-1:LARGE_SHIFT], va[LARGE_SHIFT-1:0]};
         end
         2'b10: begin
            size = PG_SMALL;
            pa   = {desc[ADDR_W-1:SMALL_SHIFT], va[SMALL_SHIFT-1:0]};
         end
         2'b11: begin
            size = PG_TINY;
            pa   = {desc[ADDR_W-1:TINY_SHIFT], va[TINY_SHIFT-1:0]};
         end
         default: fault = 1'b1;
      endcase
   end

   logic unused_l2_bits;
   assign unused_l2_bits = ^{desc[9:6], desc[3:2]};

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_walk_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter bit FINE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_va,
   input  logic [ADDR_W-1:0] req_ttb,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              done_valid,
   output logic [ADDR_W-1:0] done_pa,
   output logic [1:0]        done_ap,
   output logic              fault_valid,
   output logic              fault_level,
   output logic              tlb_wr_en,
   output logic [ADDR_W-1:0] tlb_wr_va,
   output logic [ADDR_W-1:0] tlb_wr_pa,
   output logic [1:0]        tlb_wr_ap,
   output logic [1:0]        tlb_wr_size,
   output logic [3:0]        tlb_wr_dom
);

   localparam int TTB_W = ADDR_W - TTB_SHIFT;

   if (ADDR_W != 32) begin : g_bad_width
      $error("xlat_walker: descriptor layout requires ADDR_W == 32");
   end

   walk_state_e       state_q;
   logic [ADDR_W-1:0] va_q;
   logic [TTB_W-1:0]  ttb_q;
   logic [ADDR_W-1:0] l2_addr_q;
   logic [DOM_W-1:0]  dom_q;

   l1_kind_e          l1_kind;
   logic [ADDR_W-1:0] l1_sec_pa, l1_l2_addr;
   logic [AP_W-1:0]   l1_ap;
   logic [DOM_W-1:0]  l1_dom;

   logic              l2_fault;
   pg_size_e          l2_size;
   logic [ADDR_W-1:0] l2_pa;
   logic [AP_W-1:0]   l2_ap;

   xlat_l1_decode #(.ADDR_W(ADDR_W), .FINE_EN(FINE_EN)) u_l1 (
      .desc(mem_rdata), .va(va_q), .kind(l1_kind), .sec_pa(l1_sec_pa),
      .l2_addr(l1_l2_addr), .ap(l1_ap), .dom(l1_dom)
   );

   xlat_l2_decode #(.ADDR_W(ADDR_W)) u_l2 (
      .desc(mem_rdata), .va(va_q), .fault(l2_fault), .size(l2_size),
      .pa(l2_pa), .ap(l2_ap)
   );

   logic [ADDR_W-1:0] l1_fetch_addr;
   assign l1_fetch_addr = {ttb_q, va_q[ADDR_W-1:SEC_SHIFT], 2'b00};
   assign busy     = (state_q != W_IDLE);
   assign mem_req  = (state_q != W_IDLE);
   assign mem_addr = (state_q == W_L2) ? l2_addr_q : l1_fetch_addr;

   // result of the current fetch, when it ends the walk
   logic              fin_ok, fin_fault, fin_lvl, go_l2;
   logic [ADDR_W-1:0] fin_pa;
   logic [AP_W-1:0]   fin_ap;
   pg_size_e          fin_size;
   logic [DOM_W-1:0]  fin_dom;

   always_comb begin
      fin_ok    = 1'b0;
      fin_fault = 1'b0;
      fin_lvl   = 1'b0;
      go_l2     = 1'b0;
      fin_pa    = l2_pa;
      fin_ap    = l2_ap;
      fin_size  = l2_size;
      fin_dom   = dom_q;
      if (mem_valid) begin
         case (state_q)
            W_L1: begin
               case (l1_kind)
                  L1_FAULT:   fin_fault = 1'b1;
                  L1_SECTION: begin
                     fin_ok   = 1'b1;
                     fin_pa   = l1_sec_pa;
                     fin_ap   = l1_ap;
                     fin_size = PG_SECTION;
                     fin_dom  = l1_dom;
                  end
                  default:    go_l2 = 1'b1;
               endcase
            end
            W_L2: begin
               if (l2_fault) begin
                  fin_fault = 1'b1;
                  fin_lvl   = 1'b1;
               end else begin
                  fin_ok = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= W_IDLE;
         va_q        <= '0;
         ttb_q       <= '0;
         l2_addr_q   <= '0;
         dom_q       <= '0;
         done_valid  <= 1'b0;
         done_pa     <= '0;
         done_ap     <= '0;
         fault_valid <= 1'b0;
         fault_level <= 1'b0;
         tlb_wr_en   <= 1'b0;
         tlb_wr_size <= '0;
         tlb_wr_dom  <= '0;
      end else begin
         done_valid  <= fin_ok;
         tlb_wr_en   <= fin_ok;
         fault_valid <= fin_fault;
         if (fin_ok) begin
            done_pa     <= fin_pa;
            done_ap     <= fin_ap;
            tlb_wr_size <= fin_size;
            tlb_wr_dom  <= fin_dom;
         end
         if (fin_fault) fault_level <= fin_lvl;
         if (go_l2) begin
            l2_addr_q <= l1_l2_addr;
            dom_q     <= l1_dom;
         end
         case (state_q)
            W_IDLE: if (req_valid) begin
               va_q    <= req_va;
               ttb_q   <= req_ttb[ADDR_W-1:TTB_SHIFT];
               state_q <= W_L1;
            end
            W_L1: begin
               if (go_l2) state_q <= W_L2;
               else if (fin_ok || fin_fault) state_q <= W_IDLE;
            end
            W_L2: if (mem_valid) state_q <= W_IDLE;
            default: state_q <= W_IDLE;
         endcase
      end
   end

   assign tlb_wr_va = va_q;
   assign tlb_wr_pa = done_pa;
   assign tlb_wr_ap = done_ap;

   logic unused_ttb_low;
   assign unused_ttb_low = ^req_ttb[TTB_SHIFT-1:0];

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_valid,
   input logic              done_valid,
   input logic              fault_valid,
   input logic              tlb_wr_en,
   input logic [ADDR_W-1:0] tlb_wr_va,
   input logic [ADDR_W-1:0] tlb_wr_pa,
   input logic [1:0]        tlb_wr_size
);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   assert_sec_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_wr_en && tlb_wr_size == 2'd0) |-> (tlb_wr_pa[19:0] == tlb_wr_va[19:0]));

   assert_small_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_wr_en && tlb_wr_size == 2'd2) |-> (tlb_wr_pa[11:0] == tlb_wr_va[11:0]));

   assert_fault_no_tlb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> !tlb_wr_en);

   assert_result_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_valid && fault_valid));

   assert_result_after_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid || fault_valid) |-> ($past(mem_valid) && !busy));

endmodule

bind xlat_walker xlat_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
   .done_valid(done_valid), .fault_valid(fault_valid), .tlb_wr_en(tlb_wr_en),
   .tlb_wr_va(tlb_wr_va), .tlb_wr_pa(tlb_wr_pa), .tlb_wr_size(tlb_wr_size)
);

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0, req_ttb = '0;
   logic        busy, mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done_valid, fault_valid, fault_level, tlb_wr_en;
   logic [31:0] done_pa, tlb_wr_va, tlb_wr_pa;
   logic [1:0]  done_ap, tlb_wr_ap, tlb_wr_size;
   logic [3:0]  tlb_wr_dom;

   always #5 clk = ~clk;

   xlat_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_ttb(req_ttb), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done_valid(done_valid),
      .done_pa(done_pa), .done_ap(done_ap), .fault_valid(fault_valid),
      .fault_level(fault_level), .tlb_wr_en(tlb_wr_en), .tlb_wr_va(tlb_wr_va),
      .tlb_wr_pa(tlb_wr_pa), .tlb_wr_ap(tlb_wr_ap), .tlb_wr_size(tlb_wr_size),
      .tlb_wr_dom(tlb_wr_dom)
   );

   int checks = 0;
   int failures = 0;
   int lat = 0;
   int wcnt = 0;
   int fetches = 0;
   int cycles = 0;

   typedef struct {
      bit          is_fault;
      bit          flevel;
      logic [31:0] va, pa;
      logic [1:0]  ap, size;
      logic [3:0]  dom;
      string       req;
   } exp_t;

   exp_t expq[$];
   logic [31:0] mem_model [logic [31:0]];

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory responder
   always @(negedge clk) begin
      if (mem_valid) begin
         mem_valid = 1'b0;
         wcnt = 0;
      end else if (rst_n && mem_req) begin
         if (wcnt >= lat) begin
            if (mem_model.exists(mem_addr)) mem_rdata = mem_model[mem_addr];
            else begin
               check("R3", "fetch address not in table", mem_addr, 32'hFFFF_FFFF);
               mem_rdata = '0;
            end
            mem_valid = 1'b1;
            fetches++;
            wcnt = 0;
         end else wcnt++;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && (done_valid || fault_valid)) begin
         if (expq.size() == 0) check("R11", "unexpected result", 1, 0);
         else begin
            exp_t e;
            e = expq.pop_front();
            if (e.is_fault) begin
               check(e.req, "fault_valid", {31'b0, fault_valid}, 1);
               check(e.req, "fault_level", {31'b0, fault_level}, {31'b0, e.flevel});
               check("R10", "tlb_wr_en on fault", {31'b0, tlb_wr_en}, 0);
            end else begin
               check(e.req, "done_valid", {31'b0, done_valid}, 1);
               check(e.req, "done_pa", done_pa, e.pa);
               check(e.req, "done_ap", {30'b0, done_ap}, {30'b0, e.ap});
               check("R11", "tlb_wr_en with done", {31'b0, tlb_wr_en}, 1);
               check("R11", "tlb_wr_va", tlb_wr_va, e.va);
               check("R11", "tlb_wr_pa", tlb_wr_pa, e.pa);
               check("R11", "tlb_wr_ap", {30'b0, tlb_wr_ap}, {30'b0, e.ap});
               check(e.req, "tlb_wr_size", {30'b0, tlb_wr_size}, {30'b0, e.size});
               check(e.req, "tlb_wr_dom", {28'b0, tlb_wr_dom}, {28'b0, e.dom});
            end
         end
      end else if (rst_n && tlb_wr_en) check("R11", "tlb write outside result", 1, 0);
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 50000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic walk(string req, logic [31:0] va, logic [31:0] ttb,
                       logic [31:0] d1, logic [31:0] d2, int l, bit poke);
      exp_t e;
      logic [31:0] l1a, l2a;
      int expf;
      l1a = {ttb[31:14], va[31:20], 2'b00};
      mem_model.delete();
      mem_model[l1a] = d1;
      e.va = va; e.req = req; e.is_fault = 0; e.flevel = 0;
      e.dom = d1[8:5]; e.ap = d2[5:4]; e.pa = '0; e.size = '0;
      expf = 2;
      l2a = '0;
      case (d1[1:0])
         2'b00: begin e.is_fault = 1; expf = 1; end
         2'b10: begin
            expf = 1; e.pa = {d1[31:20], va[19:0]}; e.ap = d1[11:10]; e.size = 2'd0;
         end
         2'b01: l2a = {d1[31:10], va[19:12], 2'b00};
         default: l2a = {d1[31:12], va[19:10], 2'b00};
      endcase
      if (expf == 2) begin
         mem_model[l2a] = d2;
         case (d2[1:0])
            2'b00: begin e.is_fault = 1; e.flevel = 1; end
            2'b01: begin e.pa = {d2[31:16], va[15:0]}; e.size = 2'd1; end
            2'b10: begin e.pa = {d2[31:12], va[11:0]}; e.size = 2'd2; end
            default: begin e.pa = {d2[31:10], va[9:0]}; e.size = 2'd3; end
         endcase
      end
      expq.push_back(e);
      lat = l;
      fetches = 0;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_ttb = ttb;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2", "busy after accept", {31'b0, busy}, 1);
      if (poke) begin
         req_valid = 1'b1; req_va = ~va; req_ttb = ~ttb;
         @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
      end
      for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
      @(negedge clk);
      check(req, "fetch count", fetches, expf);
      check("R2", "busy after result", {31'b0, busy}, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         check("R2", "no walk from ignored request", {30'b0, busy, mem_req}, 0);
         check("R2", "no extra fetch", fetches, expf);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "outputs in reset",
            {27'b0, busy, mem_req, done_valid, fault_valid, tlb_wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset",
            {27'b0, busy, mem_req, done_valid, fault_valid, tlb_wr_en}, 0);

      // section, immediate reply
      walk("R4", 32'h1234_5678, 32'h0004_0000,
           32'hABC0_0000 | (32'd3 << 10) | (32'd5 << 5) | 32'd2, 32'h0, 0, 0);
      // section, slow memory, request poked while busy
      walk("R2", 32'hFEDC_BA98, 32'h8001_C000,
           32'h0550_0000 | (32'd1 << 10) | (32'd9 << 5) | 32'd2, 32'h0, 4, 1);
      // coarse table to large page
      walk("R7", 32'h00AB_CDEF, 32'h1000_0000,
           32'h3344_5400 | (32'd7 << 5) | 32'd1, 32'h9876_0000 | (32'd2 << 4) | 32'd1, 1, 0);
      // coarse table to small page
      walk("R8", 32'h7F12_3456, 32'h2222_4000,
           32'h0ABC_DC00 | (32'd12 << 5) | 32'd1, 32'h5555_A000 | (32'd3 << 4) | 32'd2, 2, 0);
      // fine table to tiny page
      walk("R9", 32'h4000_07FF, 32'h3000_8000,
           32'h7777_7000 | (32'd15 << 5) | 32'd3, 32'hCAFE_BC00 | (32'd1 << 4) | 32'd3, 0, 0);
      // fine table to small page
      walk("R6", 32'h9ABC_DEF0, 32'h0FFF_C000,
           32'h1111_2000 | (32'd4 << 5) | 32'd3, 32'h2468_A000 | (32'd0 << 4) | 32'd2, 3, 0);
      // coarse table, zero latency, large page
      walk("R5", 32'hC0DE_1234, 32'h5000_4000,
           32'h0020_0400 | (32'd1 << 5) | 32'd1, 32'hF00D_0000 | (32'd3 << 4) | 32'd1, 0, 0);
      // level-one fault
      walk("R10", 32'h0BAD_0000, 32'h6000_0000, 32'hFFFF_FFFC, 32'h0, 2, 0);
      // level-two fault via coarse table
      walk("R10", 32'h3210_FEDC, 32'h7000_C000,
           32'h0101_0000 | (32'd2 << 5) | 32'd1, 32'hFFFF_FFF0, 1, 0);
      // fine table to large page
      walk("R6", 32'h5A5A_5A5A, 32'hA5A5_8000,
           32'h0F0F_0000 | (32'd6 << 5) | 32'd3, 32'h1357_0000 | (32'd1 << 4) | 32'd1, 3, 0);

      check("R11", "no leftover expected results", expq.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule